// File: doc/BRIEF.md
# Debug Communications Channel Mailbox

This block is a two-way mailbox between an external debug host and software running on a processor core. It has two one-word slots that work independently of each other. The core fills the core-to-host slot and the host empties it. The host fills the host-to-core slot and the core empties it. Each slot has a full flag that the hardware sets and clears. Both flags are visible to both sides, so words moving in the two directions can be held at the same time without one overwriting the other.

The core side is a plain register port: a write strobe with a data word, a read strobe, the host-to-core data, and both flags. The host side is a 34-bit scan chain driven by three strobes:

- **Capture** loads a status-and-data word.
- **Shift** moves the chain one bit, least significant bit first.
- **Update** commits the shifted word.

The host selects read or write mode when it captures. Bits 31..0 of the chain carry data. Bit 32 is a ready bit, and the host keeps scanning until it reads as set. Bit 33 reports the full flag of the slot for the other direction, so the host can poll both slots in one scan.

The chain is controlled by a state machine with three states:

| State | Meaning |
|---|---|
| CH_IDLE | Waiting for a capture. |
| CH_CAPT | A capture has just loaded the chain. |
| CH_SHIFT | At least one shift has happened since the capture. |

Its transitions are:

| Transition | Trigger | Effect |
|---|---|---|
| CH_IDLE → CH_CAPT | capture | Loads the chain. |
| CH_CAPT → CH_SHIFT | first shift | Shifts the chain. |
| CH_SHIFT → CH_SHIFT | each further shift | Shifts the chain. |
| CH_CAPT → CH_IDLE | update | Commits nothing. |
| CH_SHIFT → CH_IDLE | update | Commits the word if the capture selected write mode. |
| any state → CH_CAPT | capture | Reloads the chain. |

At a single clock edge, capture takes priority over update, and update takes priority over shift. Shift strobes are ignored in CH_IDLE.

Top module: `dcc_mailbox`

## Requirements
- R1: After a synchronous active-high reset, both full flags are 0, the host-to-core data seen by the core is 0, and the serial output is 0.
- R2: A core write while the core-to-host slot is empty stores core_wr_data and sets c2h_full at the same clock edge.
- R3: A core write while c2h_full is 1 is ignored, and the stored word is unchanged.
- R4: A capture in read mode (host_sel=0) loads the chain with {h2c_full, c2h_full, core-to-host data[31:0]} and clears c2h_full at that edge.
- R5: Each shift in CH_CAPT or CH_SHIFT moves the chain right by one bit. host_tdo is always chain bit 0, and host_tdi enters at bit 33. Scanning 34 bits therefore returns the captured word least significant bit first.
- R6: A capture in write mode (host_sel=1) loads {c2h_full, not h2c_full, 32 zero bits}. An update after at least one shift stores chain bits 31..0 into the host-to-core slot and sets h2c_full.
- R7: A host write commit while h2c_full is 1 is ignored, and the host-to-core data is unchanged.
- R8: core_rd_data always shows the host-to-core data, and a core read while h2c_full is 1 clears that flag at the next edge.
- R9: An update that follows a capture with no shift in between, or that ends a read-mode scan, commits nothing.
- R10: A word held in each direction at the same time is delivered intact to its reader, with both flags reading 1 until each slot is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_wr_en | input | 1 | Core write strobe for the core-to-host slot |
| core_wr_data | input | 32 | Word written by the core |
| core_rd_en | input | 1 | Core read strobe for the host-to-core slot |
| core_rd_data | output | 32 | Host-to-core slot contents |
| c2h_full | output | 1 | Core-to-host slot holds an unread word |
| h2c_full | output | 1 | Host-to-core slot holds an unread word |
| host_capture | input | 1 | Capture strobe for the scan chain |
| host_shift | input | 1 | Shift strobe for the scan chain |
| host_update | input | 1 | Update strobe for the scan chain |
| host_sel | input | 1 | Scan mode latched at capture: 0 read, 1 write |
| host_tdi | input | 1 | Serial input to the scan chain |
| host_tdo | output | 1 | Serial output, chain bit 0 |

## Verification
The assertions check every cycle that:

- a flag rises only on a write;
- a write into a full slot leaves its data stable;
- a read of a full slot clears its flag;
- a shifted-in bit lands at the top of the chain;
- a read capture puts data bit 0 on host_tdo;
- no commit follows directly on a capture.

Only the bench scenarios can show whole-word behaviour. This covers the exact field layout of the captured word in both modes, a word returned intact after 34 shifts, and a rejected host write leaving the old word. It also covers the no-shift and read-mode updates staying without effect, and two words held at once in opposite directions.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
    localparam int DATA_W  = 32;
    localparam int CHAIN_W = DATA_W + 2;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_CAPT  = 2'd1,
        CH_SHIFT = 2'd2
    } chain_state_t;
endpackage

// File: rtl/dcc_slot.sv
module dcc_slot #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] data,
    output logic         full
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
            full <= 1'b0;
        end else if (wr_en && !full) begin
            data <= wr_data;
            full <= 1'b1;
        end else if (rd_en && full) begin
            full <= 1'b0;
        end
    end

    // R2
    full_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(full) |-> $past(wr_en));

    // R3 and R7
    ignore_full_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full) |=> $stable(data));

    // R8
    rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && full && !wr_en) |=> !full);
endmodule

// File: rtl/dcc_scan_chain.sv
module dcc_scan_chain
    import dcc_pkg::*;
#(
    parameter int CW = CHAIN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic          shift,
    input  logic          update,
    input  logic          sel,
    input  logic          tdi,
    input  logic [CW-1:0] cap_word,
    output logic          tdo,
    output logic          commit,
    output logic [CW-3:0] commit_data
);
    chain_state_t state, state_nx;
    logic [CW-1:0] shreg;
    logic          wr_mode;

    always_comb begin
        state_nx = state;
        unique case (state)
            CH_IDLE:  if (capture) state_nx = CH_CAPT;
            CH_CAPT:  if (capture) state_nx = CH_CAPT;
                      else if (update) state_nx = CH_IDLE;
                      else if (shift) state_nx = CH_SHIFT;
            CH_SHIFT: if (capture) state_nx = CH_CAPT;
                      else if (update) state_nx = CH_IDLE;
            default:  state_nx = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= CH_IDLE;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            wr_mode <= 1'b0;
        end else if (capture) begin
            shreg   <= cap_word;
            wr_mode <= sel;
        end else if (!update && shift && state != CH_IDLE) begin
            shreg   <= {tdi, shreg[CW-1:1]};
        end
    end

    always_comb begin
        tdo         = shreg[0];
        commit_data = shreg[CW-3:0];
        commit      = 1'b0;
        unique case (state)
            CH_SHIFT: commit = update && !capture && wr_mode;
            default:  commit = 1'b0;
        endcase
    end

    // R9
    no_early_commit_chk: assert property (@(posedge clk) disable iff (rst)
        capture |=> !commit);

    // R5
    shift_in_chk: assert property (@(posedge clk) disable iff (rst)
        (shift && !capture && !update && state != CH_IDLE) |=> (shreg[CW-1] == $past(tdi)));
endmodule

// File: rtl/dcc_mailbox.sv
module dcc_mailbox
    import dcc_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          core_wr_en,
    input  logic [DW-1:0] core_wr_data,
    input  logic          core_rd_en,
    output logic [DW-1:0] core_rd_data,
    output logic          c2h_full,
    output logic          h2c_full,
    input  logic          host_capture,
    input  logic          host_shift,
    input  logic          host_update,
    input  logic          host_sel,
    input  logic          host_tdi,
    output logic          host_tdo
);
    localparam int CW = DW + 2;

    logic [DW-1:0] c2h_data;
    logic [CW-1:0] cap_word;
    logic          commit;
    logic [DW-1:0] commit_data;
    logic          host_rd;

    assign host_rd  = host_capture && !host_sel;
    assign cap_word = host_sel ? {c2h_full, !h2c_full, {DW{1'b0}}}
                               : {h2c_full, c2h_full, c2h_data};

    dcc_slot #(.W(DW)) i_c2h (
        .clk(clk), .rst(rst),
        .wr_en(core_wr_en), .wr_data(core_wr_data),
        .rd_en(host_rd), .data(c2h_data), .full(c2h_full)
    );

    dcc_slot #(.W(DW)) i_h2c (
        .clk(clk), .rst(rst),
        .wr_en(commit), .wr_data(commit_data),
        .rd_en(core_rd_en), .data(core_rd_data), .full(h2c_full)
    );

    dcc_scan_chain #(.CW(CW)) i_chain (
        .clk(clk), .rst(rst),
        .capture(host_capture), .shift(host_shift), .update(host_update),
        .sel(host_sel), .tdi(host_tdi), .cap_word(cap_word),
        .tdo(host_tdo), .commit(commit), .commit_data(commit_data)
    );

    // R4
    capture_lsb_chk: assert property (@(posedge clk) disable iff (rst)
        host_rd |=> (host_tdo == $past(c2h_data[0])));
endmodule

// File: tb/test_dcc_mailbox.sv
module test_dcc_mailbox;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        core_wr_en = 1'b0;
    logic [31:0] core_wr_data = '0;
    logic        core_rd_en = 1'b0;
    logic [31:0] core_rd_data;
    logic        c2h_full, h2c_full;
    logic        host_capture = 1'b0, host_shift = 1'b0, host_update = 1'b0;
    logic        host_sel = 1'b0, host_tdi = 1'b0;
    logic        host_tdo;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dcc_mailbox i_dcc_mailbox (
        .clk(clk), .rst(rst),
        .core_wr_en(core_wr_en), .core_wr_data(core_wr_data),
        .core_rd_en(core_rd_en), .core_rd_data(core_rd_data),
        .c2h_full(c2h_full), .h2c_full(h2c_full),
        .host_capture(host_capture), .host_shift(host_shift),
        .host_update(host_update), .host_sel(host_sel),
        .host_tdi(host_tdi), .host_tdo(host_tdo)
    );

    task automatic chk(input string req, input logic [67:0] act, input logic [67:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic core_write(input logic [31:0] d);
        core_wr_en = 1'b1; core_wr_data = d;
        tick();
        core_wr_en = 1'b0;
    endtask

    task automatic core_read();
        core_rd_en = 1'b1;
        tick();
        core_rd_en = 1'b0;
    endtask

    // capture in mode sel, n shifts feeding din LSB first, optional update; tdo collected
    task automatic scan(input logic sel, input logic [67:0] din, input int n,
                        input bit upd, output logic [67:0] dout);
        dout = '0;
        host_sel = sel; host_capture = 1'b1;
        tick();
        host_capture = 1'b0;
        for (int i = 0; i < n; i++) begin
            dout[i] = host_tdo;
            host_tdi = din[i]; host_shift = 1'b1;
            tick();
        end
        host_shift = 1'b0; host_tdi = 1'b0;
        if (upd) begin
            host_update = 1'b1;
            tick();
            host_update = 1'b0;
        end
    endtask

    task automatic t_reset();
        chk("R1 c2h_full", c2h_full, 0);
        chk("R1 h2c_full", h2c_full, 0);
        chk("R1 rd_data", core_rd_data, 0);
        chk("R1 tdo", host_tdo, 0);
    endtask

    task automatic t_core_to_host();
        logic [67:0] o;
        core_write(32'hA5C3_0F71);
        chk("R2 c2h_full set", c2h_full, 1);
        core_write(32'h1111_2222);
        chk("R3 still full", c2h_full, 1);
        scan(1'b0, '0, 34, 1'b1, o);
        chk("R3 data kept", o[31:0], 32'hA5C3_0F71);
        chk("R4 ready bit", o[32], 1);
        chk("R4 other flag", o[33], 0);
        chk("R4 flag cleared", c2h_full, 0);
        scan(1'b0, '0, 34, 1'b1, o);
        chk("R4 empty ready", o[32], 0);
    endtask

    task automatic t_shift_through();
        logic [67:0] o;
        logic [67:0] pat;
        pat = {34'h0, 34'h2_DEAD_BEEF};
        scan(1'b0, pat, 68, 1'b0, o);
        chk("R5 word emerges", o[67:34], 34'h2_DEAD_BEEF);
        host_update = 1'b1; tick(); host_update = 1'b0;
        chk("R9 read-mode update", h2c_full, 0);
    endtask

    task automatic t_host_to_core();
        logic [67:0] o;
        scan(1'b1, {36'h0, 32'h1234_5678}, 34, 1'b1, o);
        chk("R6 ready empty", o[32], 1);
        chk("R6 other flag", o[33], 0);
        chk("R6 zero data", o[31:0], 0);
        chk("R6 h2c_full", h2c_full, 1);
        chk("R6 data", core_rd_data, 32'h1234_5678);
        scan(1'b1, {36'h0, 32'h0BAD_F00D}, 34, 1'b1, o);
        chk("R6 ready full", o[32], 0);
        chk("R7 data kept", core_rd_data, 32'h1234_5678);
        core_read();
        chk("R8 flag cleared", h2c_full, 0);
        chk("R8 data visible", core_rd_data, 32'h1234_5678);
    endtask

    task automatic t_no_shift_update();
        logic [67:0] o;
        scan(1'b1, '0, 0, 1'b1, o);
        chk("R9 no-shift update", h2c_full, 0);
        chk("R9 data same", core_rd_data, 32'h1234_5678);
    endtask

    task automatic t_both_ways();
        logic [67:0] o;
        core_write(32'hCAFE_0001);
        scan(1'b1, {36'h0, 32'h7777_0002}, 34, 1'b1, o);
        chk("R10 other flag in write", o[33], 1);
        chk("R10 c2h_full", c2h_full, 1);
        chk("R10 h2c_full", h2c_full, 1);
        scan(1'b0, '0, 34, 1'b0, o);
        chk("R10 host gets core word", o[31:0], 32'hCAFE_0001);
        chk("R10 bit33 h2c full", o[33], 1);
        chk("R10 core gets host word", core_rd_data, 32'h7777_0002);
        core_read();
        chk("R10 both empty", {c2h_full, h2c_full}, 0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_core_to_host();
        t_shift_through();
        t_host_to_core();
        t_no_shift_update();
        t_both_ways();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule